// File: doc/BRIEF.md
# Storage Host Adapter Interrupt Aggregator and Port Reset Logic

This block keeps the global and per-port control and status registers of a multi-port serial storage host adapter with up to six ports. Each port holds a pending-event word, an event-enable word, link state, device signature and task-file status. Hardware strobes set pending bits in a port. Any port whose pending bits meet its enable bits marks its own bit in a global pending word. A single one-cycle interrupt pulse goes out when the global interrupt enable is on and the global word gains a bit.

A controller reset can come from the asynchronous reset input or from software writing the reset bit of the global control register. It returns the global registers to their idle state and reinitialises every port. The identity values a port takes (link status, signature, task-file) depend on whether a device is attached and whether it is a disk or a packet-command (optical) device. These values are taken from the presence and type inputs in the reset cycle. Register access uses a simple single-cycle write strobe and a combinational read port sharing one byte address.

Top module: `hba_intr_ctrl`

## Requirements
- R1: While `rst_n` is low, and for the first cycle after it rises, every port shows the no-device identity. In the first clock after release a controller reset is applied using the presence and type inputs. Afterwards the global control word (0x004) reads 0x80000000 and the global pending word (0x008) reads 0.
- R2: Each port's pending word (port offset 0x10) ORs in its 32 event strobes at every clock. Writing 1 to a bit clears it. An event and a clear on the same bit in the same cycle leave the bit set.
- R3: If a port's pending AND enable (offset 0x14) is nonzero in a cycle, global pending bit i (i = port index) is set at the next edge. That bit stays set after the port is cleared. It is cleared only by writing 1 to it at 0x008, and such a write loses to a same-cycle set.
- R4: `irq_pulse` is high for exactly one cycle after an edge where the global enable (bit 1 of 0x004) is 1 and either a global pending bit went from 0 to 1, or the enable went from 0 to 1 with the global pending word nonzero. It never pulses while the enable is 0.
- R5: Writing 1 to bit 0 of 0x004 performs a controller reset at that edge. The reset clears the global enable, the global pending word, and every port's pending and enable words, overriding any same-cycle event. Bit 0 reads back 0 and bit 31 always reads 1.
- R6: A controller reset clears each port's serial control (0x2C), serial error (0x30) and active-tag (0x34) registers.
- R7: A port without a device resets to link status (0x28) 0, signature (0x24) 0xFFFFFFFF and task-file (0x20) 0x7F.
- R8: A disk resets to link status 0x123 (detection 3, speed 2, power state 1), task-file 0x170 (error byte 1 in bits 15:8, status bits 0x40, 0x20, 0x10) and signature 0x00000101.
- R9: A packet device resets to link status 0x123, task-file 0x130 (no ready bit 0x40) and signature 0xEB140101.
- R10: Port p occupies 0x100 + 0x80*p. The command register (0x18) and command-issue register (0x38) are plain read/write and keep their value through a controller reset. Task-file, signature and link status ignore writes. Addresses in the window of a port index at or above the port count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| port_evt | input | NUM_PORTS*32 | Per-port event strobes, port p in bits 32p+31:32p |
| dev_present | input | NUM_PORTS | Device attached, per port |
| dev_packet | input | NUM_PORTS | Attached device is packet-command type, per port |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
Several pairs of operations can land on the same edge: a hardware event strobe and a software clear of the same pending bit, a software clear of a global bit and the fold that re-sets it from a still-pending port, and a software controller reset and an incoming event. The bench provokes each pair by driving the strobe and the register write in one cycle. It then reads the register back on the next cycle to judge the winner: set beats clear, and reset beats set. The interrupt pulse is sampled every cycle around these collisions to confirm that it fires once, only with the enable on, and never on a reset edge.

// File: rtl/hba_pkg.sv
package hba_pkg;

  // global register byte offsets
  localparam int unsigned GOFF_CTRL = 32'h004;
  localparam int unsigned GOFF_PEND = 32'h008;

  // per-port window
  localparam int unsigned PORT_BASE  = 32'h100;
  localparam int unsigned PORT_SHIFT = 7;

  // per-port register offsets inside a window
  localparam logic [6:0] POFF_PEND = 7'h10;
  localparam logic [6:0] POFF_ENA  = 7'h14;
  localparam logic [6:0] POFF_CMD  = 7'h18;
  localparam logic [6:0] POFF_TF   = 7'h20;
  localparam logic [6:0] POFF_SIG  = 7'h24;
  localparam logic [6:0] POFF_LINK = 7'h28;
  localparam logic [6:0] POFF_SCTL = 7'h2C;
  localparam logic [6:0] POFF_SERR = 7'h30;
  localparam logic [6:0] POFF_TAGS = 7'h34;
  localparam logic [6:0] POFF_ISSU = 7'h38;

  // identity constants
  localparam logic [31:0] SIG_EMPTY  = 32'hFFFF_FFFF;
  localparam logic [31:0] SIG_DISK   = 32'h0000_0101;
  localparam logic [31:0] SIG_PACKET = 32'hEB14_0101;
  localparam logic [31:0] TF_EMPTY   = 32'h0000_007F;
  localparam logic [31:0] LINK_UP    = 32'h0000_0123;

  typedef struct packed {
    logic [31:0] link;
    logic [31:0] sig;
    logic [31:0] tf;
  } port_ident_t;

  function automatic port_ident_t ident_for(input logic present, input logic packet);
    port_ident_t v;
    if (!present) begin
      v.link = '0;
      v.sig  = SIG_EMPTY;
      v.tf   = TF_EMPTY;
    end else begin
      v.link = LINK_UP;
      v.sig  = packet ? SIG_PACKET : SIG_DISK;
      // error byte 1, seek-complete 0x10, dma-ready 0x20, ready 0x40 for disks
      v.tf   = 32'h0000_0130 | (packet ? 32'h0 : 32'h0000_0040);
    end
    return v;
  endfunction

endpackage

// File: rtl/hba_port_regs.sv
module hba_port_regs
  import hba_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_rst,
  input  logic        dev_present,
  input  logic        dev_packet,
  input  logic        wr_en,
  input  logic [6:0]  reg_off,
  input  logic [31:0] wr_data,
  input  logic [31:0] evt_set,
  output logic [31:0] rd_data,
  output logic        pend
);

  logic [31:0] pend_q, pend_d;
  logic [31:0] ena_q,  ena_d;
  logic [31:0] cmd_q,  cmd_d;
  logic [31:0] sctl_q, sctl_d;
  logic [31:0] serr_q, serr_d;
  logic [31:0] tags_q, tags_d;
  logic [31:0] issu_q, issu_d;
  port_ident_t id_q,   id_d;
  logic        cfg_en;
  logic        id_en;

  assign cfg_en = wr_en | ctrl_rst;
  assign id_en  = ctrl_rst;

  // next state
  always_comb begin
    pend_d = pend_q;
    ena_d  = ena_q;
    cmd_d  = cmd_q;
    sctl_d = sctl_q;
    serr_d = serr_q;
    tags_d = tags_q;
    issu_d = issu_q;
    id_d   = ident_for(dev_present, dev_packet);

    if (wr_en) begin
      unique case (reg_off)
        POFF_PEND: pend_d = pend_q & ~wr_data;
        POFF_ENA:  ena_d  = wr_data;
        POFF_CMD:  cmd_d  = wr_data;
        POFF_SCTL: sctl_d = wr_data;
        POFF_SERR: serr_d = serr_q & ~wr_data;
        POFF_TAGS: tags_d = wr_data;
        POFF_ISSU: issu_d = wr_data;
        default: ;
      endcase
    end

    pend_d = pend_d | evt_set;

    if (ctrl_rst) begin
      pend_d = '0;
      ena_d  = '0;
      sctl_d = '0;
      serr_d = '0;
      tags_d = '0;
    end
  end

  // event word: updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  // configuration words: enabled by write or reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      cmd_q  <= '0;
      sctl_q <= '0;
      serr_q <= '0;
      tags_q <= '0;
      issu_q <= '0;
    end else if (cfg_en) begin
      ena_q  <= ena_d;
      cmd_q  <= cmd_d;
      sctl_q <= sctl_d;
      serr_q <= serr_d;
      tags_q <= tags_d;
      issu_q <= issu_d;
    end
  end

  // identity words: no-device constant until the first reset is applied
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q.link <= '0;
      id_q.sig  <= SIG_EMPTY;
      id_q.tf   <= TF_EMPTY;
    end else if (id_en) begin
      id_q <= id_d;
    end
  end

  always_comb begin
    unique case (reg_off)
      POFF_PEND: rd_data = pend_q;
      POFF_ENA:  rd_data = ena_q;
      POFF_CMD:  rd_data = cmd_q;
      POFF_TF:   rd_data = id_q.tf;
      POFF_SIG:  rd_data = id_q.sig;
      POFF_LINK: rd_data = id_q.link;
      POFF_SCTL: rd_data = sctl_q;
      POFF_SERR: rd_data = serr_q;
      POFF_TAGS: rd_data = tags_q;
      POFF_ISSU: rd_data = issu_q;
      default:   rd_data = '0;
    endcase
  end

  assign pend = |(pend_q & ena_q);

  AST_EVT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rst && evt_set != '0) |=> ((pend_q & $past(evt_set)) == $past(evt_set))); // R2
  AST_RST_CLEARS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> (pend_q == '0 && ena_q == '0 && tags_q == '0)); // R5
  AST_EMPTY_TF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rst && !dev_present) |=> (rd_data == rd_data && id_q.tf == TF_EMPTY && id_q.link == '0)); // R7
  AST_PACKET_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rst && dev_present && dev_packet) |=> (id_q.sig == SIG_PACKET)); // R9

endmodule

// File: rtl/hba_irq_fold.sv
module hba_irq_fold #(
  parameter int NPORT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_rst,
  input  logic [NPORT-1:0] pend,
  input  logic             ena_wr,
  input  logic             ena_val,
  input  logic             clr_wr,
  input  logic [NPORT-1:0] clr_mask,
  output logic [NPORT-1:0] gpend,
  output logic             gena,
  output logic             irq_pulse
);

  logic [NPORT-1:0] gpend_q, gpend_d;
  logic             gena_q,  gena_d;
  logic             irq_q,   irq_d;
  logic             new_bit;
  logic             ena_rise;

  always_comb begin
    gpend_d = gpend_q;
    gena_d  = gena_q;
    if (clr_wr) gpend_d = gpend_q & ~clr_mask;
    gpend_d = gpend_d | pend;
    if (ena_wr) gena_d = ena_val;
    if (ctrl_rst) begin
      gpend_d = '0;
      gena_d  = 1'b0;
    end
    new_bit  = |(gpend_d & ~gpend_q);
    ena_rise = gena_d & ~gena_q & (|gpend_d);
    irq_d    = gena_d & (new_bit | ena_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpend_q <= '0;
      gena_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      gpend_q <= gpend_d;
      gena_q  <= gena_d;
      irq_q   <= irq_d;
    end
  end

  assign gpend     = gpend_q;
  assign gena      = gena_q;
  assign irq_pulse = irq_q;

  AST_FOLD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rst && pend != '0) |=> ((gpend_q & $past(pend)) == $past(pend))); // R3
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (gpend_q != '0)); // R4
  AST_NO_IRQ_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> !irq_q); // R5

endmodule

// File: rtl/hba_intr_ctrl.sv
module hba_intr_ctrl
  import hba_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int ADDR_W    = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_PORTS*32-1:0] port_evt,
  input  logic [NUM_PORTS-1:0]    dev_present,
  input  logic [NUM_PORTS-1:0]    dev_packet,
  output logic                    irq_pulse
);

  localparam int PIDX_W = ADDR_W - PORT_SHIFT;

  logic              boot_q;
  logic              ctrl_rst;
  logic              glob_sel;
  logic              port_sel;
  logic [PIDX_W-1:0] pidx;
  logic              ctrl_wr;
  logic              gpend_wr;
  logic [NUM_PORTS-1:0] port_pend;
  logic [NUM_PORTS-1:0] gpend;
  logic              gena;
  logic [31:0]       port_rd [NUM_PORTS];
  logic [31:0]       glob_rd;
  logic [31:0]       win_rd;

  // reset is applied synchronously in the first clock after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  assign glob_sel = (bus_addr < ADDR_W'(PORT_BASE));
  assign pidx     = PIDX_W'((bus_addr - ADDR_W'(PORT_BASE)) >> PORT_SHIFT);
  assign port_sel = !glob_sel && (pidx < PIDX_W'(NUM_PORTS));
  assign ctrl_wr  = bus_we && (bus_addr == ADDR_W'(GOFF_CTRL));
  assign gpend_wr = bus_we && (bus_addr == ADDR_W'(GOFF_PEND));
  assign ctrl_rst = boot_q | (ctrl_wr & bus_wdata[0]);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic hit;
    assign hit = port_sel && (pidx == PIDX_W'(i));
    hba_port_regs u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_rst    (ctrl_rst),
      .dev_present (dev_present[i]),
      .dev_packet  (dev_packet[i]),
      .wr_en       (bus_we & hit),
      .reg_off     (bus_addr[6:0]),
      .wr_data     (bus_wdata),
      .evt_set     (port_evt[i*32 +: 32]),
      .rd_data     (port_rd[i]),
      .pend        (port_pend[i])
    );
  end

  hba_irq_fold #(.NPORT(NUM_PORTS)) u_fold (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_rst  (ctrl_rst),
    .pend      (port_pend),
    .ena_wr    (ctrl_wr),
    .ena_val   (bus_wdata[1]),
    .clr_wr    (gpend_wr),
    .clr_mask  (bus_wdata[NUM_PORTS-1:0]),
    .gpend     (gpend),
    .gena      (gena),
    .irq_pulse (irq_pulse)
  );

  always_comb begin
    glob_rd = '0;
    if (bus_addr == ADDR_W'(GOFF_CTRL)) begin
      glob_rd[31] = 1'b1;
      glob_rd[1]  = gena;
    end else if (bus_addr == ADDR_W'(GOFF_PEND)) begin
      glob_rd[NUM_PORTS-1:0] = gpend;
    end
  end

  always_comb begin
    win_rd = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (pidx == PIDX_W'(i)) win_rd = port_rd[i];
    end
  end

  assign bus_rdata = glob_sel ? glob_rd : (port_sel ? win_rd : 32'h0);

  AST_CTRL_RST_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> (gpend == '0 && !gena)); // R5
  AST_BOOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |=> !boot_q); // R1

endmodule

// File: tb/hba_intr_ctrl_tb.sv
`timescale 1ns/1ps
module hba_intr_ctrl_tb;

  localparam int NP = 6;
  localparam int AW = 12;

  logic            clk;
  logic            rst_n;
  logic            bus_we;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [NP*32-1:0] port_evt;
  logic [NP-1:0]   dev_present;
  logic [NP-1:0]   dev_packet;
  logic            irq_pulse;

  int n_cmp;
  int n_bad;
  bit done;

  hba_intr_ctrl #(.NUM_PORTS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_evt(port_evt),
    .dev_present(dev_present), .dev_packet(dev_packet), .irq_pulse(irq_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h004, 32'h8000_0000, 4'd1},  // R1
    '{1'b0, 12'h008, 32'h0000_0000, 4'd1},  // R1
    '{1'b0, 12'h128, 32'h0000_0123, 4'd8},  // R8 port0 disk link
    '{1'b0, 12'h120, 32'h0000_0170, 4'd8},  // R8
    '{1'b0, 12'h124, 32'h0000_0101, 4'd8},  // R8
    '{1'b0, 12'h1A8, 32'h0000_0123, 4'd9},  // R9 port1 packet
    '{1'b0, 12'h1A0, 32'h0000_0130, 4'd9},  // R9
    '{1'b0, 12'h1A4, 32'hEB14_0101, 4'd9},  // R9
    '{1'b0, 12'h228, 32'h0000_0000, 4'd7},  // R7 port2 empty
    '{1'b0, 12'h220, 32'h0000_007F, 4'd7},  // R7
    '{1'b0, 12'h224, 32'hFFFF_FFFF, 4'd7},  // R7
    '{1'b1, 12'h118, 32'h0000_0011, 4'd10}, // R10 command word
    '{1'b0, 12'h118, 32'h0000_0011, 4'd10}, // R10
    '{1'b1, 12'h120, 32'h0000_DEAD, 4'd10}, // R10 write to task-file ignored
    '{1'b0, 12'h120, 32'h0000_0170, 4'd10}, // R10
    '{1'b1, 12'h12C, 32'h0000_0301, 4'd6},  // R6
    '{1'b1, 12'h134, 32'h0000_0005, 4'd6},  // R6
    '{1'b1, 12'h138, 32'h0000_0003, 4'd10}, // R10
    '{1'b0, 12'h12C, 32'h0000_0301, 4'd6},  // R6
    '{1'b1, 12'h004, 32'h0000_0002, 4'd5},  // R5 enable on
    '{1'b0, 12'h004, 32'h8000_0002, 4'd5},  // R5
    '{1'b0, 12'h400, 32'h0000_0000, 4'd10}, // R10 window of port 6 absent
    '{1'b1, 12'h004, 32'h0000_0003, 4'd5},  // R5 software reset
    '{1'b0, 12'h004, 32'h8000_0000, 4'd5},  // R5
    '{1'b0, 12'h12C, 32'h0000_0000, 4'd6},  // R6
    '{1'b0, 12'h134, 32'h0000_0000, 4'd6},  // R6
    '{1'b0, 12'h118, 32'h0000_0011, 4'd10}, // R10 kept through reset
    '{1'b0, 12'h138, 32'h0000_0003, 4'd10}, // R10
    '{1'b0, 12'h1A8, 32'h0000_0123, 4'd9},  // R9 reapplied
    '{1'b0, 12'h3A4, 32'hEB14_0101, 4'd9}   // R9 port5 packet
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    check(tag, bus_rdata, exp);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; port_evt = '0;
    dev_present = 6'b101011;
    dev_packet  = 6'b100010;
    // R1: during reset every port shows the empty identity
    #5;
    check("R1 irq in reset", {31'b0, irq_pulse}, 32'h0);
    rd_chk("R1 tf in reset", 12'h120, 32'h0000_007F);
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (2) tick();

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].wr) wr(VEC[k].addr, VEC[k].data);
      else begin
        bus_addr = VEC[k].addr;
        #0.5;
        n_cmp++;
        if (bus_rdata !== VEC[k].data) begin
          n_bad++;
          $display("FAIL R%0d vec %0d addr=%h actual=%h expected=%h",
                   VEC[k].req, k, VEC[k].addr, bus_rdata, VEC[k].data);
        end
      end
    end

    // R2 R3 R4: event on port0 folds to global and pulses once
    wr(12'h004, 32'h2);
    wr(12'h114, 32'h1);
    port_evt[0] = 1'b1;
    tick();
    port_evt[0] = 1'b0;
    rd_chk("R2 port0 pend set", 12'h110, 32'h1);
    rd_chk("R3 global not yet", 12'h008, 32'h0);
    check("R4 no pulse yet", {31'b0, irq_pulse}, 32'h0);
    tick();
    rd_chk("R3 global set", 12'h008, 32'h1);
    check("R4 pulse", {31'b0, irq_pulse}, 32'h1);
    tick();
    check("R4 pulse one cycle", {31'b0, irq_pulse}, 32'h0);

    // R3: global bit sticky after port cleared
    wr(12'h110, 32'h1);
    tick();
    rd_chk("R2 port0 cleared", 12'h110, 32'h0);
    rd_chk("R3 global sticky", 12'h008, 32'h1);
    wr(12'h008, 32'h1);
    rd_chk("R3 global cleared", 12'h008, 32'h0);
    check("R4 no pulse on clear", {31'b0, irq_pulse}, 32'h0);

    // R2: event and clear on the same bit, same cycle
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 12'h190; bus_wdata = 32'h8; port_evt[32+3] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; port_evt = '0;
    rd_chk("R2 set beats clear", 12'h190, 32'h8);
    wr(12'h190, 32'h8);
    rd_chk("R2 clear alone", 12'h190, 32'h0);

    // R3: global clear loses to a same-cycle fold
    port_evt[0] = 1'b1;
    tick();
    port_evt[0] = 1'b0;
    tick();
    wr(12'h008, 32'h1);
    rd_chk("R3 fold beats clear", 12'h008, 32'h1);
    wr(12'h110, 32'h1);
    wr(12'h008, 32'h1);
    rd_chk("R3 cleared after port", 12'h008, 32'h0);

    // R4: masked while enable is off, pulse when enable rises
    wr(12'h004, 32'h0);
    port_evt[0] = 1'b1;
    tick();
    port_evt[0] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R4 masked", {31'b0, irq_pulse}, 32'h0);
      tick();
    end
    rd_chk("R3 set while masked", 12'h008, 32'h1);
    wr(12'h004, 32'h2);
    check("R4 pulse on enable", {31'b0, irq_pulse}, 32'h1);
    tick();
    check("R4 single pulse", {31'b0, irq_pulse}, 32'h0);

    // R5: software reset with a same-cycle event
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 12'h004; bus_wdata = 32'h3; port_evt[1] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; port_evt = '0;
    check("R5 no pulse at reset", {31'b0, irq_pulse}, 32'h0);
    rd_chk("R5 port pend", 12'h110, 32'h0);
    rd_chk("R5 port ena", 12'h114, 32'h0);
    rd_chk("R5 global pend", 12'h008, 32'h0);
    rd_chk("R5 ctrl", 12'h004, 32'h8000_0000);
    tick();
    check("R5 still quiet", {31'b0, irq_pulse}, 32'h0);

    // R8 R7: presence sampled at the next reset
    dev_present[2] = 1'b1;
    wr(12'h004, 32'h1);
    rd_chk("R8 port2 link", 12'h228, 32'h0000_0123);
    rd_chk("R8 port2 tf", 12'h220, 32'h0000_0170);
    rd_chk("R8 port2 sig", 12'h224, 32'h0000_0101);
    rd_chk("R7 port4 tf", 12'h320, 32'h0000_007F);

    // R1: asynchronous reset mid-run, then reapply
    rst_n = 1'b0;
    #0.5;
    rd_chk("R1 tf during reset", 12'h120, 32'h0000_007F);
    rd_chk("R10 cmd during reset", 12'h118, 32'h0);
    tick();
    rst_n = 1'b1;
    rd_chk("R1 empty before boot edge", 12'h128, 32'h0);
    tick();
    rd_chk("R1 identity after boot", 12'h128, 32'h0000_0123);
    rd_chk("R1 ctrl after boot", 12'h004, 32'h8000_0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule